// File: doc/BRIEF.md
# Programmable Processor Watchdog

This block watches over a processor by running a countdown that software must restart before it runs out. A single 8-bit setting sets the length of the countdown. It holds a five-bit binary multiplier and a two-bit resolution code. The timeout is the multiplier times the base period that the code selects. The countdown advances only on a fixed reference pulse of one sixteenth of a second, which a clock prescaler elsewhere supplies. An internal divider of 1, 4, 16 or 64 turns that pulse into the selected resolution.

Each write to the setting restarts the countdown from the new value, and that write is how software refreshes the watchdog. When the countdown runs out, a sticky flag is raised and the active-low alarm output goes low. Both stay that way until software reads the flag. The countdown then reloads and keeps running. A multiplier of zero turns the watchdog off. While the system runs on its backup supply, the countdown is held at its full value and cannot expire.

Top module: `wdt_supervisor`

## Requirements
- R1: After reset the flag is 0, the alarm output is 1 and the watchdog is disabled (multiplier 0).
- R2: A write takes the multiplier from data bits 6:2 and the resolution code from bits 1:0. Bit 7 is ignored and has no effect on the timeout.
- R3: With multiplier M, codes 00, 01, 10 and 11 make the flag rise on the M, 4M, 16M or 64M-th base pulse after the write, and not earlier.
- R4: A write before expiry restarts the countdown from its full length.
- R5: A multiplier of 0 never lets the flag rise, whatever base pulses arrive.
- R6: While backup is high the watchdog cannot expire. When backup is released, the full timeout is counted again.
- R7: On expiry the flag is set and the alarm output is driven low. Both hold until a read strobe clears them.
- R8: If expiry and a read strobe fall in the same cycle, the flag is set.
- R9: After expiry the countdown reloads, so the next expiry follows after another full timeout.
- R10: A base pulse in the same cycle as a write is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_tick | input | 1 | One-cycle reference pulse every 1/16 s |
| wr_en | input | 1 | Write strobe for the watchdog setting |
| wr_data | input | 8 | Setting: [6:2] multiplier, [1:0] resolution code |
| rd_flag | input | 1 | Read strobe for the flag; clears it |
| backup | input | 1 | High while running on backup supply |
| flag_o | output | 1 | Watchdog expiry flag |
| alarm_n | output | 1 | Active-low alarm, low while the flag is set |

## Verification
Every result is registered once after the stimulus. A write reloads the counters at the edge where it is sampled. The base pulse that completes the timeout sets the flag at that same edge, and a read strobe clears the flag at its own edge. The bench drives inputs and samples outputs on falling edges. It reads the flag and alarm half a cycle after the rising edge that should change them. Timeout checks probe the flag one pulse before the expected count and then exactly at it. Idle cycles between pulses show that only base pulses advance the count.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int REG_W  = 8;

  typedef enum logic [RES_W-1:0] {
    RES_SIXTEENTH = 2'b00,
    RES_QUARTER   = 2'b01,
    RES_ONE       = 2'b10,
    RES_FOUR      = 2'b11
  } res_e;
endpackage

// File: rtl/wdt_cfg_reg.sv
`timescale 1ns/1ps
module wdt_cfg_reg #(
  parameter int MULT_W = wdt_pkg::MULT_W,
  parameter int RES_W  = wdt_pkg::RES_W,
  parameter int REG_W  = wdt_pkg::REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [MULT_W-1:0] mult_q,
  output logic [RES_W-1:0]  res_q
);
  localparam int MULT_LSB = RES_W;
  localparam int MULT_MSB = RES_W + MULT_W - 1;

  logic [MULT_W-1:0] mult_d;
  logic [RES_W-1:0]  res_d;

  always_comb begin
    mult_d = mult_q;
    res_d  = res_q;
    if (wr_en) begin
      mult_d = wr_data[MULT_MSB:MULT_LSB];
      res_d  = wr_data[RES_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      res_q  <= '0;
    end else if (wr_en) begin
      mult_q <= mult_d;
      res_q  <= res_d;
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
  parameter int RES_W = wdt_pkg::RES_W,
  parameter int PRE_W = 2 * ((1 << RES_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [RES_W-1:0] res,
  output logic             res_tick
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d, last;
  logic             cnt_en;

  // Terminal count 4**res - 1: the lowest 2*res bits set.
  always_comb begin
    for (int i = 0; i < PRE_W; i++) last[i] = (i < 2 * int'(res));
  end

  assign res_tick = step && (pcnt_q == last);
  assign cnt_en   = clear || step;

  always_comb begin
    pcnt_d = pcnt_q;
    if (clear)         pcnt_d = '0;
    else if (res_tick) pcnt_d = '0;
    else if (step)     pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt_q <= '0;
    else if (cnt_en) pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown #(
  parameter int MULT_W = wdt_pkg::MULT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MULT_W-1:0] load_val,
  input  logic              step,
  output logic              expire,
  output logic [MULT_W-1:0] cnt_q
);
  localparam logic [MULT_W-1:0] ONE = MULT_W'(1);

  logic [MULT_W-1:0] cnt_d;
  logic              cnt_en;

  assign expire = step && !load && (cnt_q == ONE);
  assign cnt_en = load || step;

  always_comb begin
    cnt_d = cnt_q;
    if (load || expire) cnt_d = load_val;
    else if (step)      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_flag.sv
`timescale 1ns/1ps
module wdt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/wdt_supervisor.sv
`timescale 1ns/1ps
module wdt_supervisor #(
  parameter int MULT_W      = wdt_pkg::MULT_W,
  parameter int RES_W       = wdt_pkg::RES_W,
  parameter int REG_W       = wdt_pkg::REG_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_flag,
  input  logic             backup,
  output logic             flag_o,
  output logic             alarm_n
);
  localparam int PRE_W    = 2 * ((1 << RES_W) - 1);
  localparam int MULT_LSB = RES_W;
  localparam int MULT_MSB = RES_W + MULT_W - 1;

  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_sync_n;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_sync_n = rs_q[SYNC_STAGES-1];

  logic [MULT_W-1:0] mult_q, cnt_q, load_val;
  logic [RES_W-1:0]  res_q;
  logic              run, load, step_base, res_tick, expire;

  wdt_cfg_reg #(.MULT_W(MULT_W), .RES_W(RES_W), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
    .mult_q(mult_q), .res_q(res_q)
  );

  assign run       = !backup && (mult_q != '0);
  assign load      = wr_en || !run;
  assign step_base = base_tick && run && !wr_en;
  assign load_val  = wr_en ? wr_data[MULT_MSB:MULT_LSB] : mult_q;

  wdt_prescaler #(.RES_W(RES_W), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .clear(load), .step(step_base),
    .res(res_q), .res_tick(res_tick)
  );

  wdt_countdown #(.MULT_W(MULT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .load_val(load_val),
    .step(res_tick), .expire(expire), .cnt_q(cnt_q)
  );

  wdt_flag u_flag (
    .clk(clk), .rst_n(rst_sync_n), .set(expire), .clr(rd_flag), .flag_q(flag_o)
  );

  assign alarm_n = !flag_o;
endmodule

// File: rtl/wdt_supervisor_chk.sv
`timescale 1ns/1ps
module wdt_supervisor_chk #(
  parameter int MULT_W = wdt_pkg::MULT_W,
  parameter int REG_W  = wdt_pkg::REG_W,
  parameter int RES_W  = wdt_pkg::RES_W
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_data,
  input logic              rd_flag,
  input logic              backup,
  input logic              expire,
  input logic [MULT_W-1:0] mult_q,
  input logic [MULT_W-1:0] cnt_q,
  input logic              flag_o
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_sync_n |=> !flag_o || !rst_sync_n);
  a_r4_write_reload: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> cnt_q == $past(wr_data[RES_W+MULT_W-1:RES_W]));
  a_r5_zero_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mult_q == '0) |-> !expire);
  a_r6_backup_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    backup |-> !expire);
  a_r7_set_on_expire: assert property (@(posedge clk) disable iff (!rst_sync_n)
    expire |=> flag_o);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_o && !rd_flag) |=> flag_o);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_flag && !expire) |=> !flag_o);
  a_r9_reload_after_expire: assert property (@(posedge clk) disable iff (!rst_sync_n)
    expire |=> cnt_q == $past(mult_q));
  a_r10_write_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> !expire);
endmodule

bind wdt_supervisor wdt_supervisor_chk #(.MULT_W(MULT_W), .REG_W(REG_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_flag(rd_flag), .backup(backup), .expire(expire), .mult_q(mult_q),
  .cnt_q(cnt_q), .flag_o(flag_o)
);

// File: tb/wdt_supervisor_test.sv
`timescale 1ns/1ps
module wdt_supervisor_test;
  logic       clk = 1'b0;
  logic       rst_n, base_tick, wr_en, rd_flag, backup;
  logic [7:0] wr_data;
  logic       flag_o, alarm_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_supervisor uut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_flag(rd_flag), .backup(backup),
    .flag_o(flag_o), .alarm_n(alarm_n)
  );

  // {setting, base pulses to expiry}
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    16'h04_01, 16'h05_04, 16'h0A_20, 16'h07_40,
    16'h7C_1F, 16'h85_04, 16'h0D_0C, 16'h06_10
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_flag(input string tag, input int exp);
    chk({tag, " flag"}, int'(flag_o), exp);
    chk({tag, " alarm_n"}, int'(alarm_n), 1 - exp);
  endtask

  task automatic cyc(input logic t, input logic w, input logic [7:0] d, input logic r);
    base_tick = t; wr_en = w; wr_data = d; rd_flag = r;
    @(negedge clk);
    base_tick = 1'b0; wr_en = 1'b0; rd_flag = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      cyc(1'b1, 1'b0, 8'h00, 1'b0);
      cyc(1'b0, 1'b0, 8'h00, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; base_tick = 1'b0; wr_en = 1'b0; rd_flag = 1'b0;
    backup = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, and disabled after reset (no expiry on pulses)
    chk_flag("R1 reset", 0);
    ticks(70);
    chk_flag("R1 disabled after reset", 0);

    // R3 / R2 / R7: table of settings and timeouts
    for (int i = 0; i < NV; i++) begin
      cyc(1'b0, 1'b1, VEC[i][15:8], 1'b0);
      ticks(int'(VEC[i][7:0]) - 1);
      chk_flag($sformatf("R3 R2 vec%0d before", i), 0);
      ticks(1);
      chk_flag($sformatf("R3 R2 vec%0d at expiry", i), 1);
      cyc(1'b0, 1'b0, 8'h00, 1'b1);
      chk_flag($sformatf("R7 vec%0d read clears", i), 0);
    end

    // R7: flag holds without a read
    cyc(1'b0, 1'b1, 8'h04, 1'b0);
    ticks(1);
    repeat (10) cyc(1'b0, 1'b0, 8'h00, 1'b0);
    chk_flag("R7 held", 1);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
    chk_flag("R7 cleared", 0);

    // R4: refresh restarts the countdown
    cyc(1'b0, 1'b1, 8'h0C, 1'b0);
    ticks(2);
    cyc(1'b0, 1'b1, 8'h0C, 1'b0);
    ticks(2);
    chk_flag("R4 refreshed", 0);
    ticks(1);
    chk_flag("R4 expiry after refresh", 1);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);

    // R9: repeated expiry after reload
    ticks(2);
    chk_flag("R9 before second expiry", 0);
    ticks(1);
    chk_flag("R9 second expiry", 1);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);

    // R5: multiplier zero disables
    cyc(1'b0, 1'b1, 8'h03, 1'b0);
    ticks(100);
    chk_flag("R5 zero multiplier", 0);

    // R6: backup holds the watchdog
    cyc(1'b0, 1'b1, 8'h08, 1'b0);
    ticks(1);
    backup = 1'b1;
    ticks(5);
    chk_flag("R6 during backup", 0);
    backup = 1'b0;
    ticks(1);
    chk_flag("R6 restarted after backup", 0);
    ticks(1);
    chk_flag("R6 expiry after backup", 1);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);

    // R8: expiry and read in the same cycle
    cyc(1'b0, 1'b1, 8'h04, 1'b0);
    cyc(1'b1, 1'b0, 8'h00, 1'b1);
    chk_flag("R8 set wins", 1);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);

    // R10: pulse together with a write is not counted
    cyc(1'b1, 1'b1, 8'h04, 1'b0);
    chk_flag("R10 pulse on write ignored", 0);
    ticks(1);
    chk_flag("R10 next pulse expires", 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule